// File: doc/BRIEF.md
# UART Interrupt Register Block

This block holds the interrupt bookkeeping of a small serial port. The serial datapath reports four kinds of event, each as a one-cycle pulse. Each pulse sets a sticky state bit. Software reaches the block through a simple 32-bit register port with separate write and read strobes. Through that port it clears state bits by writing ones, chooses which sources may interrupt, and injects events through a write-only test word. Each source has its own level-sensitive interrupt line, which is high while its state bit and its enable bit are both set.

The block is placed between the serial datapath and the interrupt controller. Each line has its own output, so the controller can route and prioritise the sources separately. The line outputs come from flops, so they change one cycle after the state or enable bits that feed them.

Top module: `uart_irq_regs`

## Requirements
- R1: After reset, the state and enable registers read as zero and all four interrupt lines are low.
- R2: Source bit positions are fixed: bit 0 is transmit watermark, bit 1 is receive watermark, bit 2 is transmit empty and bit 3 is receive overflow. An event pulse sets its bit at the next clock edge.
- R3: A write to byte offset 0x00 clears each state bit whose write-data bit is one. State bits written as zero keep their value.
- R4: A write to byte offset 0x04 loads write-data bits 3..0 into the enable register. A read of 0x04 returns the enable register.
- R5: A write to byte offset 0x08 ORs write-data bits 3..0 into the state register. A read of 0x08 returns zero.
- R6: Each interrupt line is registered. It equals the AND of its state bit and its enable bit as they stood one cycle earlier. The state register reads back unmasked by the enable register.
- R7: If an event pulse and a write-one-to-clear of the same bit fall in the same cycle, the bit ends up set.
- R8: Bits 31..4 of any read are zero, whatever value was written to them.
- R9: Offsets other than 0x00, 0x04 and 0x08, and offsets whose two low bits are nonzero, read as zero. Writes to them change nothing.
- R10: The read data is zero in any cycle in which the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 6 | Byte address of the register access |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, combinational, valid while rdEn is high |
| txWmarkEvt | input | 1 | Transmit watermark event pulse |
| rxWmarkEvt | input | 1 | Receive watermark event pulse |
| txEmptyEvt | input | 1 | Transmit empty event pulse |
| rxOvflEvt | input | 1 | Receive overflow event pulse |
| txWmarkIrq | output | 1 | Transmit watermark interrupt line |
| rxWmarkIrq | output | 1 | Receive watermark interrupt line |
| txEmptyIrq | output | 1 | Transmit empty interrupt line |
| rxOvflIrq | output | 1 | Receive overflow interrupt line |

## Verification
The assertions check on every cycle the following:
- the one-cycle lag of the interrupt lines behind state and enable
- event pulses setting their bits, including when a clear of the same bit collides with them
- clears, test injections and enable loads taking effect on the next edge
- zero upper read bits and zero read data without a strobe

Some behaviour only the bench scenarios can show. These are the fixed mapping of each named event pin to its bit and line, the test word reading zero, and writes to unmapped or misaligned offsets leaving the state untouched. Reset returning everything to zero in the middle of a run is also covered only by the bench.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam int NUM_SRC = 4;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 6;
  localparam int WORD_W  = ADDR_W - 2;

  localparam logic [WORD_W-1:0] WORD_STATE  = WORD_W'(0);
  localparam logic [WORD_W-1:0] WORD_ENABLE = WORD_W'(1);
  localparam logic [WORD_W-1:0] WORD_TEST   = WORD_W'(2);

  typedef enum logic [1:0] {
    RD_NONE   = 2'd0,
    RD_STATE  = 2'd1,
    RD_ENABLE = 2'd2
  } rdSel_e;

  typedef struct packed {
    logic   clrState;
    logic   setTest;
    logic   loadEnable;
    rdSel_e rdSel;
  } regStrobe_t;

endpackage

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int ADDR_BITS = ADDR_W
) (
  input  logic                 wrEn,
  input  logic                 rdEn,
  input  logic [ADDR_BITS-1:0] addr,
  output regStrobe_t           strb
);

  localparam int WBITS = ADDR_BITS - 2;

  logic             aligned;
  logic [WBITS-1:0] wordIdx;

  assign aligned = (addr[1:0] == 2'b00);
  assign wordIdx = addr[ADDR_BITS-1:2];

  always_comb begin
    strb            = '0;
    strb.rdSel      = RD_NONE;
    if (aligned) begin
      strb.clrState   = wrEn && (wordIdx == WBITS'(WORD_STATE));
      strb.loadEnable = wrEn && (wordIdx == WBITS'(WORD_ENABLE));
      strb.setTest    = wrEn && (wordIdx == WBITS'(WORD_TEST));
      if (rdEn) begin
        if (wordIdx == WBITS'(WORD_STATE))       strb.rdSel = RD_STATE;
        else if (wordIdx == WBITS'(WORD_ENABLE)) strb.rdSel = RD_ENABLE;
        else                                     strb.rdSel = RD_NONE;
      end
    end
  end

endmodule

// File: rtl/uart_irq_dp.sv
module uart_irq_dp
  import uart_irq_pkg::*;
#(
  parameter int SRC_N = NUM_SRC,
  parameter int DW    = DATA_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  regStrobe_t       strb,
  input  logic [SRC_N-1:0] wrBits,
  input  logic [SRC_N-1:0] evtVec,
  output logic [SRC_N-1:0] stateQ,
  output logic [SRC_N-1:0] enableQ,
  output logic [SRC_N-1:0] irqQ,
  output logic [DW-1:0]    rdData
);

  for (genvar i = 0; i < SRC_N; i++) begin : g_src
    logic stateNext;

    // Event and test injection dominate a same-cycle clear.
    always_comb begin
      stateNext = stateQ[i];
      if (strb.clrState && wrBits[i]) stateNext = 1'b0;
      if (strb.setTest && wrBits[i])  stateNext = 1'b1;
      if (evtVec[i])                  stateNext = 1'b1;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stateQ[i]  <= 1'b0;
        enableQ[i] <= 1'b0;
        irqQ[i]    <= 1'b0;
      end else begin
        stateQ[i] <= stateNext;
        if (strb.loadEnable) enableQ[i] <= wrBits[i];
        irqQ[i] <= stateQ[i] & enableQ[i];
      end
    end
  end

  always_comb begin
    unique case (strb.rdSel)
      RD_STATE:  rdData = DW'(stateQ);
      RD_ENABLE: rdData = DW'(enableQ);
      default:   rdData = '0;
    endcase
  end

endmodule

// File: rtl/uart_irq_regs.sv
module uart_irq_regs
  import uart_irq_pkg::*;
#(
  parameter int DW        = DATA_W,
  parameter int ADDR_BITS = ADDR_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic                 rdEn,
  input  logic [ADDR_BITS-1:0] addr,
  input  logic [DW-1:0]        wrData,
  output logic [DW-1:0]        rdData,
  input  logic                 txWmarkEvt,
  input  logic                 rxWmarkEvt,
  input  logic                 txEmptyEvt,
  input  logic                 rxOvflEvt,
  output logic                 txWmarkIrq,
  output logic                 rxWmarkIrq,
  output logic                 txEmptyIrq,
  output logic                 rxOvflIrq
);

  regStrobe_t         strb;
  logic [NUM_SRC-1:0] evtVec;
  logic [NUM_SRC-1:0] stateVec;
  logic [NUM_SRC-1:0] enVec;
  logic [NUM_SRC-1:0] irqVec;
  logic               unusedWrHi;

  assign evtVec     = {rxOvflEvt, txEmptyEvt, rxWmarkEvt, txWmarkEvt};
  assign unusedWrHi = ^wrData[DW-1:NUM_SRC];

  uart_irq_ctrl #(.ADDR_BITS(ADDR_BITS)) u_ctrl (
    .wrEn (wrEn),
    .rdEn (rdEn),
    .addr (addr),
    .strb (strb)
  );

  uart_irq_dp #(.SRC_N(NUM_SRC), .DW(DW)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wrBits  (wrData[NUM_SRC-1:0]),
    .evtVec  (evtVec),
    .stateQ  (stateVec),
    .enableQ (enVec),
    .irqQ    (irqVec),
    .rdData  (rdData)
  );

  assign txWmarkIrq = irqVec[0];
  assign rxWmarkIrq = irqVec[1];
  assign txEmptyIrq = irqVec[2];
  assign rxOvflIrq  = irqVec[3];

endmodule

// File: rtl/uart_irq_chk.sv
module uart_irq_chk #(
  parameter int SRC_N     = 4,
  parameter int DW        = 32,
  parameter int ADDR_BITS = 6
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 wrEn,
  input logic                 rdEn,
  input logic [ADDR_BITS-1:0] addr,
  input logic [DW-1:0]        wrData,
  input logic [DW-1:0]        rdData,
  input logic [SRC_N-1:0]     evtVec,
  input logic [SRC_N-1:0]     stateVec,
  input logic [SRC_N-1:0]     enVec,
  input logic [SRC_N-1:0]     irqVec
);

  AST_IRQ_LAGS_STATE: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> irqVec == ($past(stateVec) & $past(enVec))); // R6

  AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (|evtVec) |=> ((stateVec & $past(evtVec)) == $past(evtVec))); // R7

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_BITS'(0) && evtVec == '0)
      |=> ((stateVec & $past(wrData[SRC_N-1:0])) == '0)); // R3

  AST_TEST_INJECTS: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_BITS'(8))
      |=> ((stateVec & $past(wrData[SRC_N-1:0])) == $past(wrData[SRC_N-1:0]))); // R5

  AST_ENABLE_LOADS: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_BITS'(4)) |=> enVec == $past(wrData[SRC_N-1:0])); // R4

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    rdData[DW-1:SRC_N] == '0); // R8

  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |-> rdData == '0); // R10

endmodule

bind uart_irq_regs uart_irq_chk #(
  .SRC_N(uart_irq_pkg::NUM_SRC), .DW(DW), .ADDR_BITS(ADDR_BITS)
) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
  .wrData(wrData), .rdData(rdData), .evtVec(evtVec),
  .stateVec(stateVec), .enVec(enVec), .irqVec(irqVec)
);

// File: tb/uart_irq_regs_tb.sv
module uart_irq_regs_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 22;

  typedef struct packed {
    logic        wr;
    logic        rd;
    logic [5:0]  addr;
    logic [31:0] data;
    logic [3:0]  evt;
    logic [31:0] expRd;
    logic [3:0]  expIrq;
    logic [7:0]  req;
  } vec_t;

  // Steps run in order; expIrq is the line state once the step has settled.
  localparam vec_t TBL [NVEC] = '{
    '{1'b1, 1'b0, 6'h04, 32'hFFFF_FFFF, 4'h0, 32'h0, 4'h0, 8'd4}, // R4 enable all
    '{1'b0, 1'b1, 6'h04, 32'h0,         4'h0, 32'hF, 4'h0, 8'd8}, // R8 upper enable bits dropped
    '{1'b0, 1'b0, 6'h00, 32'h0,         4'h1, 32'h0, 4'h1, 8'd2}, // R2 tx watermark -> bit0
    '{1'b0, 1'b0, 6'h00, 32'h0,         4'h4, 32'h0, 4'h5, 8'd2}, // R2 tx empty -> bit2
    '{1'b0, 1'b1, 6'h00, 32'h0,         4'h0, 32'h5, 4'h5, 8'd2}, // R2 readback
    '{1'b1, 1'b0, 6'h00, 32'h1,         4'h0, 32'h0, 4'h4, 8'd3}, // R3 clear bit0
    '{1'b1, 1'b0, 6'h00, 32'h0,         4'h0, 32'h0, 4'h4, 8'd3}, // R3 zeros keep
    '{1'b0, 1'b1, 6'h00, 32'h0,         4'h0, 32'h4, 4'h4, 8'd3}, // R3 readback
    '{1'b1, 1'b0, 6'h08, 32'hA,         4'h0, 32'h0, 4'hE, 8'd5}, // R5 inject
    '{1'b0, 1'b1, 6'h08, 32'h0,         4'h0, 32'h0, 4'hE, 8'd5}, // R5 test reads zero
    '{1'b1, 1'b0, 6'h04, 32'h3,         4'h0, 32'h0, 4'h2, 8'd6}, // R6 mask by enable
    '{1'b0, 1'b1, 6'h00, 32'h0,         4'h0, 32'hE, 4'h2, 8'd6}, // R6 state unmasked
    '{1'b1, 1'b0, 6'h00, 32'hF,         4'h8, 32'h0, 4'h0, 8'd7}, // R7 event beats clear
    '{1'b0, 1'b1, 6'h00, 32'h0,         4'h0, 32'h8, 4'h0, 8'd7}, // R7 readback
    '{1'b1, 1'b0, 6'h0C, 32'hF,         4'h0, 32'h0, 4'h0, 8'd9}, // R9 unmapped write
    '{1'b0, 1'b1, 6'h0C, 32'h0,         4'h0, 32'h0, 4'h0, 8'd9}, // R9 unmapped read
    '{1'b1, 1'b0, 6'h09, 32'hF,         4'h0, 32'h0, 4'h0, 8'd9}, // R9 misaligned write
    '{1'b0, 1'b1, 6'h00, 32'h0,         4'h0, 32'h8, 4'h0, 8'd9}, // R9 state untouched
    '{1'b1, 1'b0, 6'h08, 32'hFFFF_FFF0, 4'h0, 32'h0, 4'h0, 8'd8}, // R8 high test bits dropped
    '{1'b0, 1'b1, 6'h00, 32'h0,         4'h0, 32'h8, 4'h0, 8'd8}, // R8 readback
    '{1'b1, 1'b0, 6'h04, 32'hF,         4'h0, 32'h0, 4'h8, 8'd6}, // R6 rx overflow line
    '{1'b1, 1'b0, 6'h00, 32'hF,         4'h0, 32'h0, 4'h0, 8'd3}  // R3 clear all
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [3:0]  evt = '0;
  logic        txWmarkIrq, rxWmarkIrq, txEmptyIrq, rxOvflIrq;
  logic [3:0]  irqObs;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  assign irqObs = {rxOvflIrq, txEmptyIrq, rxWmarkIrq, txWmarkIrq};

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_irq_regs u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData),
    .txWmarkEvt(evt[0]), .rxWmarkEvt(evt[1]), .txEmptyEvt(evt[2]), .rxOvflEvt(evt[3]),
    .txWmarkIrq(txWmarkIrq), .rxWmarkIrq(rxWmarkIrq),
    .txEmptyIrq(txEmptyIrq), .rxOvflIrq(rxOvflIrq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic readReg(input logic [5:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    #1;
    check(req, rdData, exp);
    @(negedge clk);
    rdEn = 1'b0; addr = '0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    wrEn = 1'b0; rdEn = 1'b0; addr = '0; wrData = '0; evt = '0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    doReset();
    // R1 reset state
    check("R1 irq", {28'h0, irqObs}, 32'h0);
    readReg(6'h00, 32'h0, "R1 state");
    readReg(6'h04, 32'h0, "R1 enable");

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      wrEn = TBL[i].wr; rdEn = TBL[i].rd; addr = TBL[i].addr;
      wrData = TBL[i].data; evt = TBL[i].evt;
      #1;
      if (TBL[i].rd) check($sformatf("R%0d read step %0d", TBL[i].req, i), rdData, TBL[i].expRd);
      @(negedge clk);
      wrEn = 1'b0; rdEn = 1'b0; addr = '0; wrData = '0; evt = '0;
      @(negedge clk);
      check($sformatf("R%0d irq step %0d", TBL[i].req, i), {28'h0, irqObs}, {28'h0, TBL[i].expIrq});
    end

    // R6 latency: state set at first edge, line one edge later; enable is 0xF here
    @(negedge clk);
    evt = 4'h2;
    @(negedge clk);
    evt = 4'h0; rdEn = 1'b1; addr = 6'h00;
    #1;
    check("R6 line still low", {28'h0, irqObs}, 32'h0);
    check("R2 rx watermark bit1", rdData, 32'h2);
    @(negedge clk);
    rdEn = 1'b0;
    check("R6 line after lag", {28'h0, irqObs}, 32'h2);

    // R10 no strobe, address of a nonzero register
    addr = 6'h00;
    #1;
    check("R10 idle read", rdData, 32'h0);
    addr = '0;

    // R1 reset mid-run clears everything
    doReset();
    check("R1 irq after rerun reset", {28'h0, irqObs}, 32'h0);
    readReg(6'h00, 32'h0, "R1 state after rerun reset");
    readReg(6'h04, 32'h0, "R1 enable after rerun reset");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule